// File: doc/BRIEF.md
# Extended pattern-memory bank composer

This block forms the 8-bit number of the 1 KiB pattern-memory bank (256 KiB in all) that the picture processor reaches on each access. It merges three sources. The first is a set of outer configuration registers. The second is the bank value that the inner bank controller offers for the current window. The third is the picture-address bits A12:A10, which select one of eight 1 KiB windows. Each window is handled independently and the result is purely combinational. The block is therefore placed directly in the address path, between the inner controller's window lookup and the memory address pins.

There are two modes. In controller mode, the inner value passes through, and bit 7 may instead come from an outer register. In fixed-window mode, an outer 4-bit offset gives bits 6:3 and the picture address gives bits 2:0. A quirk mode rewrites the inner value for some windows. The window key is the picture address with A12 flipped by the inner controller's pattern-mode bit. The data path has no valid/ready handshake: it is a combinational address path with no storage, so back-pressure has no meaning. Register storage belongs to the caller.

Top module: `chr_bank_composer`

## Requirements
- R1: In controller mode (`cfg_mode[4]`=0) with `cfg_outer[7]`=0 and quirk off (`cfg_mode[6]`=0), `bank_out` equals `win_val`.
- R2: When `cfg_outer[7]`=1, bit 7 of `bank_out` equals `cfg_outer[3]` in either mode. Bits 6:0 keep the value they would have with `cfg_outer[7]`=0.
- R3: In fixed-window mode (`cfg_mode[4]`=1), `bank_out[6:3]` equals `cfg_chr_ofs[3:0]` and `bank_out[2:0]` equals `ppu_win` (A12:A10).
- R4: In fixed-window mode with `cfg_outer[7]`=0 and quirk off, `bank_out[7]` equals `win_val[7]`.
- R5: The window key is `{ppu_win[2]^chr_mode_flip, ppu_win[1:0]}`. Key 0 is offset 0x0000, key 1 is 0x0400, key 2 is 0x0800 and key 3 is 0x0C00.
- R6: In quirk mode with fixed-window mode, keys 1 and 3 clear bit 7 of the inner value before it is used. Under R4 conditions `bank_out[7]` is then 0.
- R7: In quirk mode with controller mode, key 0 uses `inner_r0` in place of `win_val`, and key 2 uses `inner_r1`.
- R8: In quirk mode with controller mode, keys 1 and 3 force the inner value to 0.
- R9: Keys 4 to 7 in quirk mode, and every key with quirk off, pass `win_val` unchanged.
- R10: `bank_out` has no register stage and follows its inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_outer | input | 8 | Outer register: bit 7 selects the bit-7 source, bit 3 is the alternate bit 7 |
| cfg_chr_ofs | input | 4 | Outer bank offset for fixed-window mode (bank bits 6:3) |
| cfg_mode | input | 8 | Outer mode register: bit 4 selects fixed-window mode, bit 6 enables quirk mode |
| chr_mode_flip | input | 1 | Inner controller's pattern-mode bit; flips A12 in the window key |
| inner_r0 | input | 8 | Inner bank register 0 |
| inner_r1 | input | 8 | Inner bank register 1 |
| win_val | input | 8 | Inner controller's bank value for the current window |
| ppu_win | input | 3 | Picture address bits A12:A10 |
| bank_out | output | 8 | Composed 1 KiB bank number |

## Verification
Every result is due in the same cycle as its stimulus, with zero register stages. The bench applies inputs just after a rising edge and compares `bank_out` against a behavioural model at the following falling edge, before the next stimulus. Directed cases cover each key in each mode combination. They are followed by a long stream of pseudo-random input vectors that is compared on every clock.

// File: rtl/chr_bank_pkg.sv
package chr_bank_pkg;
  localparam int BANK_W = 8;
  localparam int WIN_W  = 3;
  localparam int OFS_W  = 4;

  typedef logic [BANK_W-1:0] bank_t;
  typedef logic [WIN_W-1:0]  win_t;

  // window keys in 1 KiB units
  localparam win_t KEY_LO_A  = 3'd0;
  localparam win_t KEY_LO_B  = 3'd1;
  localparam win_t KEY_HI_A  = 3'd2;
  localparam win_t KEY_HI_B  = 3'd3;

  // outer register bit positions
  localparam int TOPSEL_BIT = 7;
  localparam int TOPALT_BIT = 3;
  localparam int FIXED_BIT  = 4;
  localparam int QUIRK_BIT  = 6;
endpackage

// File: rtl/chr_window_key.sv
module chr_window_key
  import chr_bank_pkg::*;
(
  input  win_t ppu_win,
  input  logic flip,
  output win_t key
);
  always_comb begin
    key = ppu_win;
    key[WIN_W-1] = ppu_win[WIN_W-1] ^ flip;
  end

  always_comb begin
    if (!$isunknown({ppu_win, flip})) begin
      assert_key_low_R5: assert (key[WIN_W-2:0] == ppu_win[WIN_W-2:0])
        else $error("key low bits differ from window");
    end
  end
endmodule

// File: rtl/chr_window_quirk.sv
module chr_window_quirk
  import chr_bank_pkg::*;
(
  input  logic  quirk_en,
  input  logic  fixed_mode,
  input  win_t  key,
  input  bank_t win_val,
  input  bank_t inner_r0,
  input  bank_t inner_r1,
  output bank_t eff_val
);
  logic odd_low;
  assign odd_low = (key == KEY_LO_B) || (key == KEY_HI_B);

  always_comb begin
    eff_val = win_val;
    if (quirk_en) begin
      if (fixed_mode) begin
        if (odd_low) eff_val[BANK_W-1] = 1'b0;
      end else begin
        unique case (key)
          KEY_LO_A: eff_val = inner_r0;
          KEY_HI_A: eff_val = inner_r1;
          KEY_LO_B,
          KEY_HI_B: eff_val = '0;
          default:  eff_val = win_val;
        endcase
      end
    end
  end

  always_comb begin
    if (!$isunknown({quirk_en, fixed_mode, key, win_val})) begin
      if (quirk_en && !fixed_mode && odd_low)
        assert_zeroed_R8: assert (eff_val == '0) else $error("quirk value not zero");
      if (key[WIN_W-1])
        assert_upper_pass_R9: assert (eff_val == win_val) else $error("upper key altered");
    end
  end
endmodule

// File: rtl/chr_bank_merge.sv
module chr_bank_merge
  import chr_bank_pkg::*;
(
  input  logic             fixed_mode,
  input  logic             top_sel,
  input  logic             top_alt,
  input  logic [OFS_W-1:0] page_ofs,
  input  win_t             ppu_win,
  input  bank_t            eff_val,
  output bank_t            bank
);
  localparam int LOW_W = BANK_W - 1;

  logic [LOW_W-1:0] low_bits;
  logic             top_bit;

  generate
    if (OFS_W + WIN_W == LOW_W) begin : g_exact
      assign low_bits = fixed_mode ? {page_ofs, ppu_win} : eff_val[LOW_W-1:0];
    end else begin : g_pad
      assign low_bits = fixed_mode ? LOW_W'({page_ofs, ppu_win}) : eff_val[LOW_W-1:0];
    end
  endgenerate

  assign top_bit = top_sel ? top_alt : eff_val[BANK_W-1];
  assign bank    = {top_bit, low_bits};

  always_comb begin
    if (!$isunknown({top_sel, top_alt, bank}))
      if (top_sel)
        assert_top_alt_R2: assert (bank[BANK_W-1] == top_alt) else $error("bit7 source");
  end
endmodule

// File: rtl/chr_bank_composer.sv
module chr_bank_composer
  import chr_bank_pkg::*;
(
  input  logic [7:0] cfg_outer,
  input  logic [3:0] cfg_chr_ofs,
  input  logic [7:0] cfg_mode,
  input  logic       chr_mode_flip,
  input  logic [7:0] inner_r0,
  input  logic [7:0] inner_r1,
  input  logic [7:0] win_val,
  input  logic [2:0] ppu_win,
  output logic [7:0] bank_out
);
  logic  fixed_mode;
  logic  quirk_en;
  win_t  key;
  bank_t eff_val;

  assign fixed_mode = cfg_mode[FIXED_BIT];
  assign quirk_en   = cfg_mode[QUIRK_BIT];

  chr_window_key u_key (
    .ppu_win (ppu_win),
    .flip    (chr_mode_flip),
    .key     (key)
  );

  chr_window_quirk u_quirk (
    .quirk_en   (quirk_en),
    .fixed_mode (fixed_mode),
    .key        (key),
    .win_val    (win_val),
    .inner_r0   (inner_r0),
    .inner_r1   (inner_r1),
    .eff_val    (eff_val)
  );

  chr_bank_merge u_merge (
    .fixed_mode (fixed_mode),
    .top_sel    (cfg_outer[TOPSEL_BIT]),
    .top_alt    (cfg_outer[TOPALT_BIT]),
    .page_ofs   (cfg_chr_ofs),
    .ppu_win    (ppu_win),
    .eff_val    (eff_val),
    .bank       (bank_out)
  );

  always_comb begin
    if (!$isunknown({cfg_outer, cfg_chr_ofs, cfg_mode, win_val, ppu_win, bank_out})) begin
      if (fixed_mode)
        assert_fixed_low_R3: assert (bank_out[6:0] == {cfg_chr_ofs, ppu_win})
          else $error("fixed-window low bits");
      if (!fixed_mode && !quirk_en && !cfg_outer[7])
        assert_passthru_R1: assert (bank_out == win_val) else $error("pass-through");
    end
  end
endmodule

// File: tb/sim_chr_bank_composer.sv
module sim_chr_bank_composer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [7:0] cfg_outer, cfg_mode, inner_r0, inner_r1, win_val, bank_out;
  logic [3:0] cfg_chr_ofs;
  logic [2:0] ppu_win;
  logic       chr_mode_flip;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  chr_bank_composer u0 (
    .cfg_outer(cfg_outer), .cfg_chr_ofs(cfg_chr_ofs), .cfg_mode(cfg_mode),
    .chr_mode_flip(chr_mode_flip), .inner_r0(inner_r0), .inner_r1(inner_r1),
    .win_val(win_val), .ppu_win(ppu_win), .bank_out(bank_out)
  );

  function automatic int model();
    int key, v, res;
    bit fixed, quirk;
    fixed = cfg_mode[4];
    quirk = cfg_mode[6];
    key = (ppu_win ^ (chr_mode_flip ? 4 : 0));
    v = win_val;
    if (quirk) begin
      if (fixed) begin
        if (key == 1 || key == 3) v = v % 128;
      end else begin
        if (key == 0) v = inner_r0;
        else if (key == 2) v = inner_r1;
        else if (key == 1 || key == 3) v = 0;
      end
    end
    if (fixed) res = (v / 128) * 128 + cfg_chr_ofs * 8 + ppu_win;
    else res = v;
    if (cfg_outer[7]) res = (res % 128) + (cfg_outer[3] ? 128 : 0);
    return res;
  endfunction

  task automatic apply(input logic [7:0] o, input logic [3:0] c, input logic [7:0] m,
                       input logic f, input logic [7:0] a, input logic [7:0] b,
                       input logic [7:0] v, input logic [2:0] w, input string req);
    int exp;
    @(posedge clk); #1;
    cfg_outer = o; cfg_chr_ofs = c; cfg_mode = m; chr_mode_flip = f;
    inner_r0 = a; inner_r1 = b; win_val = v; ppu_win = w;
    @(negedge clk);
    exp = model();
    checks++;
    if (int'(bank_out) != exp) begin
      fails++;
      $display("FAIL %s: bank_out=%02h expected=%02h", req, bank_out, exp[7:0]);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog: cycles=%0d expected<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    cfg_outer = 0; cfg_chr_ofs = 0; cfg_mode = 0; chr_mode_flip = 0;
    inner_r0 = 0; inner_r1 = 0; win_val = 0; ppu_win = 0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (bank_out !== 8'h00) begin
      fails++; $display("FAIL R1 reset: bank_out=%02h expected=00", bank_out);
    end
    // R1 / R10 pass-through, same cycle
    apply(8'h00, 4'h0, 8'h00, 0, 8'h11, 8'h22, 8'hA5, 3'd5, "R1");
    apply(8'h00, 4'hF, 8'h00, 1, 8'h11, 8'h22, 8'h3C, 3'd0, "R10");
    // R2 bit 7 alternate
    apply(8'h88, 4'h0, 8'h00, 0, 8'h00, 8'h00, 8'h12, 3'd1, "R2");
    apply(8'h80, 4'h0, 8'h00, 0, 8'h00, 8'h00, 8'hFF, 3'd1, "R2");
    apply(8'h88, 4'h5, 8'h10, 0, 8'h00, 8'h00, 8'h00, 3'd6, "R2");
    // R3 / R4 fixed window
    apply(8'h00, 4'hA, 8'h10, 0, 8'h00, 8'h00, 8'h80, 3'd7, "R3");
    apply(8'h00, 4'h3, 8'h10, 1, 8'h00, 8'h00, 8'h7F, 3'd2, "R4");
    apply(8'h00, 4'h3, 8'h10, 0, 8'h00, 8'h00, 8'hFF, 3'd4, "R4");
    // R6 fixed + quirk: keys 1 and 3 clear bit 7
    apply(8'h00, 4'h6, 8'h50, 0, 8'h00, 8'h00, 8'hFF, 3'd1, "R6");
    apply(8'h00, 4'h6, 8'h50, 1, 8'h00, 8'h00, 8'hFF, 3'd7, "R6");
    apply(8'h00, 4'h6, 8'h50, 0, 8'h00, 8'h00, 8'hFF, 3'd2, "R6");
    // R7 / R5 controller + quirk: key 0 -> R0, key 2 -> R1, key via A12 flip
    apply(8'h00, 4'h0, 8'h40, 0, 8'hC3, 8'h5A, 8'h99, 3'd0, "R7");
    apply(8'h00, 4'h0, 8'h40, 0, 8'hC3, 8'h5A, 8'h99, 3'd2, "R7");
    apply(8'h00, 4'h0, 8'h40, 1, 8'hC3, 8'h5A, 8'h99, 3'd4, "R5");
    apply(8'h00, 4'h0, 8'h40, 1, 8'hC3, 8'h5A, 8'h99, 3'd6, "R5");
    // R8 forced zero
    apply(8'h00, 4'h0, 8'h40, 0, 8'hC3, 8'h5A, 8'h99, 3'd1, "R8");
    apply(8'h88, 4'h0, 8'h40, 1, 8'hC3, 8'h5A, 8'h99, 3'd7, "R8");
    // R9 upper keys pass
    apply(8'h00, 4'h0, 8'h40, 0, 8'hC3, 8'h5A, 8'h99, 3'd4, "R9");
    apply(8'h00, 4'h0, 8'h40, 1, 8'hC3, 8'h5A, 8'h77, 3'd0, "R9");
    // random stream, compared every cycle
    for (int i = 0; i < 3000; i++) begin
      apply($urandom, $urandom, $urandom, $urandom, $urandom, $urandom,
            $urandom, $urandom, "R10 random");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule